// File: doc/BRIEF.md
# Four-Tap Sum-of-Products Accumulating Filter

This block multiplies four signed data samples by four signed coefficients, adds the four products, and passes that sum through a wide accumulator. A format stage then extracts a 16-bit result. Every pair of a data sample and a coefficient sits in its own input register. Each tap has an active-low load enable, and one shared select decides which half of a pair is held when the enable is high. Because a coefficient can be held for any number of cycles while data streams past it, the input registers also act as coefficient storage. This suits small FIR kernels, mixers and bilinear interpolation.

The pipeline takes a new set of inputs on every clock and presents the matching result five rising edges later. An accumulate control chooses between restarting the total and adding to it. A format control chooses between a fractional view (the upper bits, with a half-LSB round on restart) and an integer view (the lower bits, never rounded). An output-hold control freezes the result register while accumulation continues. An asynchronous output enable gates the result bus and a drive flag.

Top module: `quad_mac_filter`

## Requirements
- R1: Each tap's registers follow its active-low enable `loadEnN[i]` and the shared `enSel`. With the enable low, both data and coefficient load. With the enable high and `enSel` low, only data loads and the coefficient is held. With the enable high and `enSel` high, only the coefficient loads and the data is held.
- R2: Data (10-bit) and coefficients (11-bit) are two's complement. Tap i uses `dataIn[10*i+9:10*i]` and `coefIn[11*i+10:11*i]`. The four signed products are summed exactly.
- R3: When `accEn` is low, the previous total is discarded and the 25-bit total becomes the current sum of products. A round term is added only under the condition of R5.
- R4: When `accEn` is high, the current sum of products is added to the running 25-bit total without rounding. Overflow wraps modulo 2^25.
- R5: When `fmtInt` is low, the result is total bits 24..9. If `accEn` was also low for that input set, 1 is added at bit 8 of the total before selection, and that round stays in the total for later accumulation.
- R6: When `fmtInt` is high, the result is total bits 15..0 and no rounding is applied.
- R7: When `outHold` is high, the result register keeps its value, while the total keeps updating.
- R8: The controls are pipelined with the data, so `accEn`, `fmtInt` and `outHold` apply to the input set of the same cycle. That set's result appears after the fifth rising edge, and a new set is accepted every cycle.
- R9: While `oeN` is high, `result` is zero and `resultDriven` is low, independent of the clock. While `oeN` is low, `result` shows the result register and `resultDriven` is high.
- R10: Synchronous active-high `rst` clears all input, pipeline, accumulator and result registers, so `result` reads zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 40 | Four packed signed 10-bit data samples, tap 0 in the low bits |
| coefIn | input | 44 | Four packed signed 11-bit coefficients, tap 0 in the low bits |
| loadEnN | input | 4 | Per-tap load enable, active low |
| enSel | input | 1 | Selects data-only (0) or coefficient-only (1) loading when a tap's enable is high |
| accEn | input | 1 | 1 adds to the running total, 0 restarts it |
| fmtInt | input | 1 | 0 selects the fractional view, 1 selects the integer view |
| outHold | input | 1 | 1 freezes the result register |
| oeN | input | 1 | Asynchronous output enable, active low |
| result | output | 16 | Result bus, zero when not driven |
| resultDriven | output | 1 | High when the result bus is enabled |

## Verification
The bench targets several corner cases:
- extreme negative times extreme negative products, where a sign-handling mistake in a multiplier or a sum-extension stage would flip or truncate the result;
- long accumulate runs with large values that wrap the 25-bit total, which a design saturating or mis-extending would miss;
- alternating restart and accumulate cycles in the fractional view, where a round applied on accumulate cycles, missing on restart, or dropped from the total would be off by one LSB;
- held taps and frozen output cycles, where a swapped enable decode or a hold that also stopped accumulation would diverge from the model several cycles later;
- toggling the output enable and an impulse after quiet cycles, which catch a control delayed by the wrong number of stages, since that pairs a format or hold setting with a neighbouring input set.

// File: rtl/qmf_pkg.sv
package qmf_pkg;
  // Strobes handed from the control pipe to the datapath.
  typedef struct packed {
    logic clearAcc;   // restart the running total with the current sum
    logic addRound;   // add half-LSB of the fractional view on restart
    logic loadOut;    // capture the total into the result register
    logic takeLow;    // integer view: low bits of the total
  } qmf_strobe_t;
endpackage

// File: rtl/qmf_ctrl.sv
module qmf_ctrl
  import qmf_pkg::*;
#(
  parameter int ACC_STAGE = 3,   // edges from input capture to the accumulator edge minus one
  parameter int OUT_STAGE = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        accEn,
  input  logic        fmtInt,
  input  logic        outHold,
  output qmf_strobe_t strobe
);
  logic [ACC_STAGE-1:0] accSh;
  logic [OUT_STAGE-1:0] fmtSh;
  logic [OUT_STAGE-1:0] holdSh;

  always_ff @(posedge clk) begin
    if (rst) begin
      accSh  <= '0;
      fmtSh  <= '0;
      holdSh <= '0;
    end else begin
      accSh  <= {accSh[ACC_STAGE-2:0], accEn};
      fmtSh  <= {fmtSh[OUT_STAGE-2:0], fmtInt};
      holdSh <= {holdSh[OUT_STAGE-2:0], outHold};
    end
  end

  always_comb begin
    strobe.clearAcc = !accSh[ACC_STAGE-1];
    strobe.addRound = !accSh[ACC_STAGE-1] && !fmtSh[ACC_STAGE-1];
    strobe.loadOut  = !holdSh[OUT_STAGE-1];
    strobe.takeLow  = fmtSh[OUT_STAGE-1];
  end

  // R8: the round request seen at the accumulator matches the format captured one edge earlier in the pipe
  assert_round_tracks_fmt_R8: assert property (@(posedge clk) disable iff (rst)
    strobe.addRound |=> !strobe.takeLow);
endmodule

// File: rtl/qmf_datapath.sv
module qmf_datapath
  import qmf_pkg::*;
#(
  parameter int TAPS   = 4,
  parameter int DATA_W = 10,
  parameter int COEF_W = 11,
  parameter int ACC_W  = 25,
  parameter int OUT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [TAPS*DATA_W-1:0]   dataIn,
  input  logic [TAPS*COEF_W-1:0]   coefIn,
  input  logic [TAPS-1:0]          loadEnN,
  input  logic                     enSel,
  input  qmf_strobe_t              strobe,
  output logic [OUT_W-1:0]         outReg
);
  localparam int PROD_W   = DATA_W + COEF_W;
  localparam int SUM_W    = PROD_W + $clog2(TAPS);
  localparam int FRAC_LSB = ACC_W - OUT_W;
  localparam logic [ACC_W-1:0] ROUND_ONE = ACC_W'(1) << (FRAC_LSB - 1);

  logic signed [DATA_W-1:0] dataReg [TAPS];
  logic signed [COEF_W-1:0] coefReg [TAPS];
  logic signed [PROD_W-1:0] prodReg [TAPS];
  logic signed [SUM_W-1:0]  sumComb;
  logic signed [SUM_W-1:0]  sumReg;
  logic [ACC_W-1:0]         sumExt;
  logic [ACC_W-1:0]         accReg;
  logic [ACC_W-1:0]         accNext;

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    logic loadData, loadCoef;
    assign loadData = !loadEnN[i] || !enSel;
    assign loadCoef = !loadEnN[i] || enSel;

    always_ff @(posedge clk) begin
      if (rst) begin
        dataReg[i] <= '0;
        coefReg[i] <= '0;
        prodReg[i] <= '0;
      end else begin
        if (loadData) dataReg[i] <= dataIn[i*DATA_W +: DATA_W];
        if (loadCoef) coefReg[i] <= coefIn[i*COEF_W +: COEF_W];
        prodReg[i] <= dataReg[i] * coefReg[i];
      end
    end

    // R1: held coefficient while data-only loading
    assert_coef_held_R1: assert property (@(posedge clk) disable iff (rst)
      (loadEnN[i] && !enSel) |=> $stable(coefReg[i]));
    // R1: held data while coefficient-only loading
    assert_data_held_R1: assert property (@(posedge clk) disable iff (rst)
      (loadEnN[i] && enSel) |=> $stable(dataReg[i]));
  end

  always_comb begin
    sumComb = '0;
    for (int i = 0; i < TAPS; i++) sumComb = sumComb + SUM_W'(prodReg[i]);
  end

  assign sumExt  = {{(ACC_W-SUM_W){sumReg[SUM_W-1]}}, sumReg};
  assign accNext = strobe.clearAcc ? (sumExt + (strobe.addRound ? ROUND_ONE : '0))
                                   : (accReg + sumExt);

  always_ff @(posedge clk) begin
    if (rst) begin
      sumReg <= '0;
      accReg <= '0;
      outReg <= '0;
    end else begin
      sumReg <= sumComb;
      accReg <= accNext;
      if (strobe.loadOut)
        outReg <= strobe.takeLow ? accReg[OUT_W-1:0] : accReg[ACC_W-1 -: OUT_W];
    end
  end

  // R4: accumulate cycles add the incoming sum to the previous total
  assert_acc_adds_R4: assert property (@(posedge clk) disable iff (rst)
    !strobe.clearAcc |=> accReg == $past(accReg) + $past(sumExt));
  // R3: an unrounded restart leaves exactly the incoming sum
  assert_acc_restart_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe.clearAcc && !strobe.addRound) |=> accReg == $past(sumExt));
  // R7: a frozen result register keeps its value
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadOut |=> $stable(outReg));
endmodule

// File: rtl/quad_mac_filter.sv
module quad_mac_filter
  import qmf_pkg::*;
#(
  parameter int TAPS   = 4,
  parameter int DATA_W = 10,
  parameter int COEF_W = 11,
  parameter int ACC_W  = 25,
  parameter int OUT_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [TAPS*DATA_W-1:0] dataIn,
  input  logic [TAPS*COEF_W-1:0] coefIn,
  input  logic [TAPS-1:0]        loadEnN,
  input  logic                   enSel,
  input  logic                   accEn,
  input  logic                   fmtInt,
  input  logic                   outHold,
  input  logic                   oeN,
  output logic [OUT_W-1:0]       result,
  output logic                   resultDriven
);
  qmf_strobe_t      strobe;
  logic [OUT_W-1:0] outReg;

  qmf_ctrl #(.ACC_STAGE(3), .OUT_STAGE(4)) ctrl_i (
    .clk(clk), .rst(rst), .accEn(accEn), .fmtInt(fmtInt),
    .outHold(outHold), .strobe(strobe)
  );

  qmf_datapath #(
    .TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .OUT_W(OUT_W)
  ) dp_i (
    .clk(clk), .rst(rst), .dataIn(dataIn), .coefIn(coefIn), .loadEnN(loadEnN),
    .enSel(enSel), .strobe(strobe), .outReg(outReg)
  );

  assign result       = oeN ? '0 : outReg;
  assign resultDriven = !oeN;

  // R9: a disabled bus reads zero
  assert_bus_off_R9: assert property (@(posedge clk) disable iff (rst)
    oeN |-> (result == '0 && !resultDriven));
  // R10: the first edge out of reset leaves the result register clear
  assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> outReg == '0);
endmodule

// File: tb/quad_mac_filter_tb_top.sv
module quad_mac_filter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [39:0] dataIn = '0;
  logic [43:0] coefIn = '0;
  logic [3:0]  loadEnN = '0;
  logic        enSel = 1'b0, accEn = 1'b0, fmtInt = 1'b0, outHold = 1'b0, oeN = 1'b0;
  logic [15:0] result;
  logic        resultDriven;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_mac_filter dut_i (
    .clk(clk), .rst(rst), .dataIn(dataIn), .coefIn(coefIn), .loadEnN(loadEnN),
    .enSel(enSel), .accEn(accEn), .fmtInt(fmtInt), .outHold(outHold), .oeN(oeN),
    .result(result), .resultDriven(resultDriven)
  );

  // Reference state, advanced once per rising edge from the requirements.
  typedef struct { logic [24:0] s; bit a; bit f; bit h; } item_t;
  logic signed [9:0]  mD [4];
  logic signed [10:0] mC [4];
  item_t       pipe [3];
  logic [24:0] mAcc;
  bit          fS4, hS4;
  logic [15:0] expOut;

  task automatic modelEdge();
    logic [24:0] s;
    if (rst) begin
      for (int j = 0; j < 4; j++) begin mD[j] = '0; mC[j] = '0; end
      for (int j = 0; j < 3; j++) pipe[j] = '{25'd0, 1'b0, 1'b0, 1'b0};
      mAcc = '0; fS4 = 0; hS4 = 0; expOut = '0;
    end else begin
      if (!hS4) expOut = fS4 ? mAcc[15:0] : mAcc[24:9];                       // R5 R6 R7
      if (!pipe[2].a) mAcc = pipe[2].s + (pipe[2].f ? 25'd0 : 25'd256);      // R3 R5
      else            mAcc = mAcc + pipe[2].s;                               // R4
      fS4 = pipe[2].f; hS4 = pipe[2].h;
      pipe[2] = pipe[1]; pipe[1] = pipe[0];
      for (int j = 0; j < 4; j++) begin                                      // R1
        if (!loadEnN[j] || !enSel) mD[j] = dataIn[j*10 +: 10];
        if (!loadEnN[j] ||  enSel) mC[j] = coefIn[j*11 +: 11];
      end
      s = '0;
      for (int j = 0; j < 4; j++) s = s + 25'(25'(mD[j]) * 25'(mC[j]));     // R2
      pipe[0] = '{s, accEn, fmtInt, outHold};
    end
  endtask

  task automatic checkOut(string tag);
    logic [15:0] expV;
    expV = oeN ? 16'h0 : expOut;
    checks++;
    if (result !== expV || resultDriven !== !oeN) begin
      errors++;
      $display("FAIL %s: result=%h driven=%b expected result=%h driven=%b",
               tag, result, resultDriven, expV, !oeN);
    end
  endtask

  task automatic runCycle(string tag);
    modelEdge();
    @(posedge clk);
    @(negedge clk);
    checkOut(tag);
  endtask

  task automatic randTaps();
    for (int j = 0; j < 4; j++) begin
      dataIn[j*10 +: 10] = 10'($urandom);
      coefIn[j*11 +: 11] = 11'($urandom);
    end
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R10: reset state
    rst = 1;
    for (int k = 0; k < 4; k++) runCycle("R10");
    rst = 0;
    for (int k = 0; k < 6; k++) runCycle("R10");

    // R2: extreme products, integer view, restart every cycle
    fmtInt = 1; accEn = 0;
    dataIn = {4{10'h200}}; coefIn = {4{11'h400}}; runCycle("R2");
    dataIn = {4{10'h1FF}}; coefIn = {4{11'h3FF}}; runCycle("R2");
    dataIn = {4{10'h200}}; coefIn = {4{11'h3FF}}; runCycle("R2");
    dataIn = {10'h001, 10'h3FF, 10'h002, 10'h3FE}; coefIn = {11'h005, 11'h005, 11'h7FF, 11'h401}; runCycle("R2");
    for (int k = 0; k < 200; k++) begin randTaps(); runCycle("R2"); end

    // R6: integer view with mixed accumulate, never rounded
    for (int k = 0; k < 200; k++) begin randTaps(); accEn = 1'($urandom); runCycle("R6"); end

    // R5: fractional restart with round
    fmtInt = 0; accEn = 0;
    for (int k = 0; k < 200; k++) begin randTaps(); runCycle("R5"); end

    // R4: long accumulation with wrap
    accEn = 1;
    dataIn = {4{10'h200}}; coefIn = {4{11'h400}};
    for (int k = 0; k < 40; k++) begin fmtInt = 1'($urandom); runCycle("R4"); end
    for (int k = 0; k < 200; k++) begin randTaps(); fmtInt = 1'($urandom); runCycle("R4"); end

    // R3: restarts interleaved with accumulation
    for (int k = 0; k < 300; k++) begin
      randTaps(); accEn = ($urandom % 3) != 0; fmtInt = 1'($urandom); runCycle("R3");
    end

    // R1: per-tap hold patterns
    for (int k = 0; k < 400; k++) begin
      randTaps(); loadEnN = 4'($urandom); enSel = 1'($urandom);
      accEn = 0; fmtInt = 1'($urandom); runCycle("R1");
    end
    loadEnN = '0;

    // R7: frozen result register while accumulating
    for (int k = 0; k < 300; k++) begin
      randTaps(); outHold = ($urandom % 4) != 0; accEn = 1'($urandom);
      fmtInt = 1'($urandom); runCycle("R7");
    end
    outHold = 0;

    // R8: impulse after quiet cycles, then per-cycle control changes
    dataIn = '0; coefIn = '0; accEn = 0; fmtInt = 1;
    for (int k = 0; k < 8; k++) runCycle("R8");
    dataIn[9:0] = 10'd3; coefIn[10:0] = 11'd7; runCycle("R8");
    dataIn = '0; coefIn = '0;
    for (int k = 0; k < 8; k++) runCycle("R8");
    for (int k = 0; k < 300; k++) begin
      randTaps(); accEn = 1'($urandom); fmtInt = 1'($urandom); outHold = 1'($urandom);
      loadEnN = 4'($urandom); enSel = 1'($urandom); runCycle("R8");
    end
    outHold = 0; loadEnN = '0;

    // R9: output enable toggling
    for (int k = 0; k < 200; k++) begin
      randTaps(); oeN = 1'($urandom); fmtInt = 1'($urandom); runCycle("R9");
    end
    oeN = 0;

    // R10: reset mid-run clears everything
    rst = 1; runCycle("R10"); runCycle("R10");
    rst = 0; dataIn = '0; coefIn = '0; accEn = 1; fmtInt = 1;
    for (int k = 0; k < 8; k++) runCycle("R10");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule